// File: doc/BRIEF.md
# Flash Identification Mode Decoder

This block decides whether the read path of a 16-bit flash array returns stored data or the fixed identification words. It watches decoded write cycles on the command interface. Two unlock-style sequences switch it into identification mode: a short three-write form and a longer six-write form. Two further commands switch it back: a single reset write, or a three-write sequence.

A separate hardware path forces identification mode. It is active while the chip and output enables are low, the write enable is high, and a flag reports the high-voltage condition on address bit 9. Sensing that voltage happens outside this block, which only receives the flag.

The outputs go to the read multiplexer. The mode flag selects the override word. The override word carries the manufacturer code at address 0 and the device code at address 1. All other addresses read as zero while the mode is active.

Top module: `flash_id_mode_dec`

## Requirements
- R1: While `rst` is high at a clock edge, the software mode and the sequence tracker return to idle. After reset, `id_mode_o` is 0 and `id_data_o` is 0000h as long as the hardware condition is absent.
- R2: When `id_mode_o` is 0, `id_data_o` is 0000h for every read address.
- R3: Three consecutive tracked writes enter software ID mode: (5555h, AAh), then (2AAAh, 55h), then (5555h, 90h), each given as (address, data low byte). `id_mode_o` rises in the cycle after the clock edge that takes the third write.
- R4: Six consecutive tracked writes also enter software ID mode with the same timing: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 60h).
- R5: A tracked write whose data low byte is F0h leaves software ID mode and returns the tracker to idle. This holds at any address and at any tracker position, and takes effect in the next cycle.
- R6: The three-write exit (5555h, AAh), (2AAAh, 55h), (5555h, F0h) leaves software ID mode.
- R7: A write that does not continue a started sequence returns the tracker to idle and leaves the current mode unchanged. A later write that would have completed the broken sequence then has no effect.
- R8: `id_mode_o` is 1 in every cycle where `ce_n`=0, `oe_n`=0, `we_n`=1 and `hv_a9`=1, whatever the software mode. Removing any one of these four conditions removes the hardware contribution in the same cycle.
- R9: When `id_mode_o` is 1, `id_data_o` is 00DAh for read address 0000h, 002Fh for 0001h, and 0000h for any other address.
- R10: Only cycles with `wr_stb`=1 are tracked writes. Idle cycles between the writes of a sequence neither break it nor change the mode. Bits 15:8 of `wr_data` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe marking a write cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data; low byte holds the command |
| rd_addr | input | 16 | Current read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hv_a9 | input | 1 | High-voltage flag on address bit 9 |
| id_mode_o | output | 1 | Read mux selects the ID word when high |
| id_data_o | output | 16 | Override word for the read mux |

## Verification
The hardware force and the software mode register can both act in the same cycle. The bench holds the hardware condition and, in the same cycles, completes a software entry, then writes the reset command. It expects the flag to stay high throughout and to drop only after the hardware condition is released and the software mode is already clear. A reset write issued in the middle of an entry sequence is also checked, because it falls on a cycle where sequence tracking and exit both apply. Every cycle is compared against a queue-based model of recent writes.

// File: rtl/flash_idm_pkg.sv
package flash_idm_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [CMD_W-1:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [CMD_W-1:0] CMD_ID_SHORT = 8'h90;
    localparam logic [CMD_W-1:0] CMD_LONG_PRE = 8'h80;
    localparam logic [CMD_W-1:0] CMD_ID_LONG  = 8'h60;
    localparam logic [CMD_W-1:0] CMD_RESET    = 8'hF0;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_U1,
        SEQ_U2,
        SEQ_L1,
        SEQ_L2,
        SEQ_L3
    } seq_e;

    // decoded write event handed from the top to the tracker
    typedef struct packed {
        logic             stb;
        logic             at_a;
        logic             at_b;
        logic [CMD_W-1:0] cmd;
    } wr_evt_t;

    function automatic logic evt_is(wr_evt_t e, logic [CMD_W-1:0] c, logic on_a);
        return e.stb && (e.cmd == c) && (on_a ? e.at_a : e.at_b);
    endfunction

endpackage

// File: rtl/idm_cmd_tracker.sv
module idm_cmd_tracker
    import flash_idm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_evt_t evt,
    output logic    sw_mode_o
);

    seq_e state_q, state_d;
    logic sw_q, sw_d;

    always_comb begin
        state_d = state_q;
        sw_d    = sw_q;
        if (evt.stb) begin
            state_d = SEQ_IDLE;
            if (evt.cmd == CMD_RESET) begin
                sw_d = 1'b0;
            end else begin
                case (state_q)
                    SEQ_IDLE: if (evt_is(evt, CMD_UNLOCK_A, 1'b1)) state_d = SEQ_U1;
                    SEQ_U1:   if (evt_is(evt, CMD_UNLOCK_B, 1'b0)) state_d = SEQ_U2;
                    SEQ_U2: begin
                        if (evt_is(evt, CMD_ID_SHORT, 1'b1))      sw_d    = 1'b1;
                        else if (evt_is(evt, CMD_LONG_PRE, 1'b1)) state_d = SEQ_L1;
                    end
                    SEQ_L1:   if (evt_is(evt, CMD_UNLOCK_A, 1'b1)) state_d = SEQ_L2;
                    SEQ_L2:   if (evt_is(evt, CMD_UNLOCK_B, 1'b0)) state_d = SEQ_L3;
                    SEQ_L3:   if (evt_is(evt, CMD_ID_LONG, 1'b1))  sw_d    = 1'b1;
                    default:  state_d = SEQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            sw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            sw_q    <= sw_d;
        end
    end

    assign sw_mode_o = sw_q;

    p_reset_cmd_exits_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.stb && evt.cmd == CMD_RESET) |=> !sw_q);

    p_short_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_U2 && evt.stb && evt.cmd == CMD_ID_SHORT && evt.at_a) |=> sw_q);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !evt.stb |=> ($stable(sw_q) && $stable(state_q)));

    p_break_keeps_mode_r7: assert property (@(posedge clk) disable iff (rst)
        (evt.stb && evt.cmd != CMD_RESET && state_q == SEQ_U1 && !evt.at_b) |=> (state_q == SEQ_IDLE && $stable(sw_q)));

endmodule

// File: rtl/idm_hw_detect.sv
module idm_hw_detect (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic hv_a9,
    output logic hw_id_o
);

    // R8: read-type bus condition plus high-voltage flag
    assign hw_id_o = ~ce_n & ~oe_n & we_n & hv_a9;

endmodule

// File: rtl/idm_code_sel.sv
module idm_code_sel #(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 16,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00DA,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h002F
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] id_data_o
);

    localparam logic [ADDR_W-1:0] MFR_ADDR = '0;
    localparam logic [ADDR_W-1:0] DEV_ADDR = ADDR_W'(1);

    always_comb begin
        id_data_o = '0;
        if (id_mode) begin
            if (rd_addr == MFR_ADDR)      id_data_o = MFR_CODE;
            else if (rd_addr == DEV_ADDR) id_data_o = DEV_CODE;
        end
    end

endmodule

// File: rtl/flash_id_mode_dec.sv
module flash_id_mode_dec
    import flash_idm_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] UNLOCK_A = 16'h5555,
    parameter logic [ADDR_W-1:0] UNLOCK_B = 16'h2AAA,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00DA,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h002F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hv_a9,
    output logic              id_mode_o,
    output logic [DATA_W-1:0] id_data_o
);

    wr_evt_t evt;
    logic    sw_mode;
    logic    hw_id;
    logic    unused_hi_bits;

    assign evt.stb  = wr_stb;
    assign evt.at_a = (wr_addr == UNLOCK_A);
    assign evt.at_b = (wr_addr == UNLOCK_B);
    assign evt.cmd  = wr_data[CMD_W-1:0];
    assign unused_hi_bits = ^wr_data[DATA_W-1:CMD_W];

    idm_cmd_tracker u_trk (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .sw_mode_o (sw_mode)
    );

    idm_hw_detect u_hw (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .hv_a9   (hv_a9),
        .hw_id_o (hw_id)
    );

    assign id_mode_o = sw_mode | hw_id;

    idm_code_sel #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_sel (
        .id_mode   (id_mode_o),
        .rd_addr   (rd_addr),
        .id_data_o (id_data_o)
    );

    p_hw_forces_mode_r8: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && we_n && hv_a9) |-> id_mode_o);

    p_mfr_word_r9: assert property (@(posedge clk) disable iff (rst)
        (id_mode_o && rd_addr == '0) |-> (id_data_o == MFR_CODE));

    p_off_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !id_mode_o |-> (id_data_o == '0));

endmodule

// File: tb/flash_id_mode_dec_tb_top.sv
module flash_id_mode_dec_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_stb;
    logic [15:0] wr_addr, wr_data, rd_addr;
    logic        ce_n, oe_n, we_n, hv_a9;
    logic        id_mode_o;
    logic [15:0] id_data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_id_mode_dec dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hv_a9(hv_a9),
        .id_mode_o(id_mode_o), .id_data_o(id_data_o)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    // behavioural model: queue of writes since the last clear
    bit          m_sw = 1'b0;
    logic [15:0] qa[$];
    logic [7:0]  qd[$];
    logic [15:0] long_a[6]  = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
    logic [7:0]  long_d[6]  = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h60};
    logic [15:0] short_a[3] = '{16'h5555, 16'h2AAA, 16'h5555};
    logic [7:0]  short_d[3] = '{8'hAA, 8'h55, 8'h90};

    function automatic bit is_prefix(bit use_long);
        int len = use_long ? 6 : 3;
        if (qa.size() > len) return 1'b0;
        for (int i = 0; i < qa.size(); i++) begin
            if (use_long) begin
                if (qa[i] != long_a[i] || qd[i] != long_d[i]) return 1'b0;
            end else begin
                if (qa[i] != short_a[i] || qd[i] != short_d[i]) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sw = 1'b0;
            qa.delete(); qd.delete();
        end else if (wr_stb) begin
            if (wr_data[7:0] == 8'hF0) begin
                m_sw = 1'b0;
                qa.delete(); qd.delete();
            end else begin
                bit p3, p6;
                qa.push_back(wr_addr);
                qd.push_back(wr_data[7:0]);
                p3 = is_prefix(1'b0);
                p6 = is_prefix(1'b1);
                if ((p3 && qa.size() == 3) || (p6 && qa.size() == 6)) begin
                    m_sw = 1'b1;
                    qa.delete(); qd.delete();
                end else if (!p3 && !p6) begin
                    qa.delete(); qd.delete();
                end
            end
        end
    end

    task automatic check();
        bit          hw = (ce_n == 1'b0) && (oe_n == 1'b0) && (we_n == 1'b1) && (hv_a9 == 1'b1);
        bit          em = m_sw | hw;
        logic [15:0] ed = 16'h0000;
        if (em) ed = (rd_addr == 16'h0000) ? 16'h00DA : (rd_addr == 16'h0001) ? 16'h002F : 16'h0000;
        checks++;
        if (id_mode_o !== em || id_data_o !== ed) begin
            fails++;
            $display("FAIL %s: mode %b exp %b, data %h exp %h", tag, id_mode_o, em, id_data_o, ed);
        end
    endtask

    task automatic cyc(input logic stb, input logic [15:0] wa, input logic [15:0] wd, input logic [15:0] ra);
        @(negedge clk);
        wr_stb = stb; wr_addr = wa; wr_data = wd; rd_addr = ra;
        #1 check();
    endtask

    task automatic wr(input logic [15:0] wa, input logic [15:0] wd);
        cyc(1'b1, wa, wd, 16'h0000);
    endtask

    task automatic rd(input logic [15:0] ra);
        cyc(1'b0, 16'h0000, 16'h0000, ra);
    endtask

    task automatic reads();
        rd(16'h0000); rd(16'h0001); rd(16'h0002); rd(16'h8001);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_stb = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; hv_a9 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        tag = "R1"; rd(16'h0000);
        tag = "R2"; reads();

        tag = "R3"; wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
        tag = "R9"; reads();

        tag = "R5"; wr(16'h1234, 16'h00F0); reads();

        tag = "R4";
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0060);
        reads();
        tag = "R6"; wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00F0); reads();

        tag = "R7";
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0012); wr(16'h5555, 16'h0090); reads();
        wr(16'h1234, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090); reads();
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h5555, 16'h0055); wr(16'h5555, 16'h0060); reads();
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0033); reads();

        tag = "R5"; wr(16'h5555, 16'h00AA); wr(16'h0000, 16'h00F0); reads();
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h00F0); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090); reads();

        tag = "R10";
        wr(16'h5555, 16'hC3AA); rd(16'h0000); wr(16'h2AAA, 16'h7F55); rd(16'h0001); rd(16'h0000);
        wr(16'h5555, 16'hFF90); reads();
        cyc(1'b0, 16'h5555, 16'h00F0, 16'h0000); cyc(1'b0, 16'h0000, 16'h00F0, 16'h0001);
        wr(16'h4444, 16'hABF0); reads();

        tag = "R8";
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; hv_a9 = 1'b1; reads();
        hv_a9 = 1'b0; rd(16'h0000); hv_a9 = 1'b1;
        ce_n = 1'b1;  rd(16'h0000); ce_n = 1'b0;
        oe_n = 1'b1;  rd(16'h0001); oe_n = 1'b0;
        we_n = 1'b0;  rd(16'h0000); we_n = 1'b1;
        rd(16'h0001);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090); reads();
        wr(16'h0000, 16'h00F0); reads();
        hv_a9 = 1'b0; reads();
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
        hv_a9 = 1'b1; reads(); hv_a9 = 1'b0; reads();
        ce_n = 1'b1; oe_n = 1'b1;

        tag = "R1"; @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; rd(16'h0000); rd(16'h0001);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule